// File: doc/BRIEF.md
# Bit-Sliced Six-Function Integer ALU

This block is a purely combinational integer ALU built from a row of identical one-bit slices. Each slice can invert either operand bit. It then picks one of four candidates: the bitwise AND, the bitwise OR, a full-adder sum, or a "less" input. The slice carries ripple from bit 0 upward. Six functions come out of this one structure: AND, OR, add, subtract, signed set-less-than and NOR. The choice is made by a 4-bit control word. Bit 3 inverts A. Bit 2 inverts B and also supplies the carry into bit 0. Bits 1:0 choose the slice multiplexer input.

For set-less-than, the top slice produces a sign indication of A minus B that is corrected for overflow. That signal is routed back to the less input of bit 0. Every other slice has its less input tied low. A flag stage beside the slice row forms the Zero, signed Overflow and CarryOut outputs. It also blanks the result and the flags for any control code outside the six defined ones.

Top module: `bsalu_top`

## Requirements
- R1: Control code 4'b0000 gives result = A AND B.
- R2: Control code 4'b0001 gives result = A OR B.
- R3: Control code 4'b0010 gives result = (A + B) modulo 2^W. carry_out is the carry out of the top bit, so it is 1 exactly when the unsigned sum does not fit in W bits.
- R4: Control code 4'b0110 gives result = (A - B) modulo 2^W. carry_out is 1 exactly when A >= B as unsigned numbers, meaning no borrow.
- R5: On add and subtract, overflow is 1 exactly when the signed result leaves the W-bit two's complement range. For add this is two operands of equal sign giving a sum of the other sign. For subtract it is operands of differing sign where the result sign differs from A.
- R6: Control code 4'b0111 gives result bit 0 = 1 when A < B as signed two's complement numbers, and 0 otherwise. This holds also when A - B overflows. Result bits W-1..1 are 0.
- R7: Control code 4'b1100 gives result = NOT (A OR B).
- R8: zero is 1 exactly when the control code is one of the six defined codes and every result bit is 0.
- R9: For AND, OR, NOR and set-less-than, overflow and carry_out are both 0.
- R10: Any other control code gives result = 0, zero = 0, overflow = 0 and carry_out = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | DATA_W (32) | Operand A |
| opd_b | input | DATA_W (32) | Operand B |
| fn_sel | input | 4 | Control word: [3] invert A, [2] invert B and carry-in, [1:0] slice select |
| result | output | DATA_W (32) | Function result |
| zero | output | 1 | Result is all zeros under a defined code |
| overflow | output | 1 | Signed overflow on add or subtract |
| carry_out | output | 1 | Carry out of top slice on add or subtract |

## Verification
On every evaluation, the assertions compare the add and subtract outputs and the unsigned borrow against arithmetic on the ports. They also check the set-less-than bit against a signed comparison, that the flags stay quiet on logical functions and on undefined codes, and that zero agrees with the result. The bench's scenarios are needed for the rest. These are the bitwise functions on patterned and random data and the exact signed overflow boundaries. They also include set-less-than at the extremes of the signed range, where A minus B overflows and the raw sign bit gives the wrong answer.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
   localparam int FN_W = 4;

   localparam logic [1:0] SEL_AND  = 2'b00;
   localparam logic [1:0] SEL_OR   = 2'b01;
   localparam logic [1:0] SEL_SUM  = 2'b10;
   localparam logic [1:0] SEL_LESS = 2'b11;

   localparam logic [FN_W-1:0] FN_AND = 4'b0000;
   localparam logic [FN_W-1:0] FN_OR  = 4'b0001;
   localparam logic [FN_W-1:0] FN_ADD = 4'b0010;
   localparam logic [FN_W-1:0] FN_SUB = 4'b0110;
   localparam logic [FN_W-1:0] FN_SLT = 4'b0111;
   localparam logic [FN_W-1:0] FN_NOR = 4'b1100;

   typedef struct packed {
      logic       inv_a;
      logic       inv_b;
      logic [1:0] sel;
   } fn_word_t;

   function automatic logic fn_is_defined(input logic [FN_W-1:0] f);
      return (f == FN_AND) || (f == FN_OR) || (f == FN_ADD) ||
             (f == FN_SUB) || (f == FN_SLT) || (f == FN_NOR);
   endfunction

   function automatic logic fn_is_arith(input logic [FN_W-1:0] f);
      return (f == FN_ADD) || (f == FN_SUB);
   endfunction
endpackage

// File: rtl/bsalu_slice.sv
module bsalu_slice
   import bsalu_pkg::*;
(
   input  logic       a,
   input  logic       b,
   input  logic       inv_a,
   input  logic       inv_b,
   input  logic [1:0] sel,
   input  logic       cin,
   input  logic       less,
   output logic       sum,
   output logic       cout,
   output logic       res
);
   logic aa;
   logic bb;

   always_comb begin
      aa   = a ^ inv_a;
      bb   = b ^ inv_b;
      sum  = aa ^ bb ^ cin;
      cout = (aa & bb) | (cin & (aa ^ bb));
      unique case (sel)
         SEL_AND:  res = aa & bb;
         SEL_OR:   res = aa | bb;
         SEL_SUM:  res = sum;
         default:  res = less;
      endcase
   end
endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags
   import bsalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [FN_W-1:0]   fn_sel,
   input  logic [DATA_W-1:0] raw_res,
   input  logic              sum_msb,
   input  logic              carry_into_msb,
   input  logic              carry_from_msb,
   output logic              set_lt,
   output logic [DATA_W-1:0] result,
   output logic              zero,
   output logic              overflow,
   output logic              carry_out
);
   logic defined;
   logic arith;
   logic ovf_raw;

   always_comb begin
      defined   = fn_is_defined(fn_sel);
      arith     = fn_is_arith(fn_sel);
      ovf_raw   = carry_into_msb ^ carry_from_msb;
      set_lt    = sum_msb ^ ovf_raw;
      result    = defined ? raw_res : '0;
      zero      = defined & ~|raw_res;
      overflow  = arith & ovf_raw;
      carry_out = arith & carry_from_msb;
   end
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
   import bsalu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] opd_a,
   input  logic [DATA_W-1:0] opd_b,
   input  logic [FN_W-1:0]   fn_sel,
   output logic [DATA_W-1:0] result,
   output logic              zero,
   output logic              overflow,
   output logic              carry_out
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bsalu_top: DATA_W must be at least 2");
      end
   endgenerate

   fn_word_t          fw;
   logic [DATA_W:0]   cy;
   logic [DATA_W-1:0] sums;
   logic [DATA_W-1:0] raw_res;
   logic              set_lt;

   assign fw    = fn_word_t'(fn_sel);
   assign cy[0] = fw.inv_b;

   genvar i;
   generate
      for (i = 0; i < DATA_W; i++) begin : g_slice
         logic less_in;
         if (i == 0) begin : g_lsb
            assign less_in = set_lt;
         end else begin : g_upper
            assign less_in = 1'b0;
         end
         bsalu_slice u_slice (
            .a     (opd_a[i]),
            .b     (opd_b[i]),
            .inv_a (fw.inv_a),
            .inv_b (fw.inv_b),
            .sel   (fw.sel),
            .cin   (cy[i]),
            .less  (less_in),
            .sum   (sums[i]),
            .cout  (cy[i+1]),
            .res   (raw_res[i])
         );
      end
   endgenerate

   bsalu_flags #(.DATA_W(DATA_W)) u_flags (
      .fn_sel         (fn_sel),
      .raw_res        (raw_res),
      .sum_msb        (sums[MSB]),
      .carry_into_msb (cy[MSB]),
      .carry_from_msb (cy[DATA_W]),
      .set_lt         (set_lt),
      .result         (result),
      .zero           (zero),
      .overflow       (overflow),
      .carry_out      (carry_out)
   );

   logic [DATA_W:0] chk_add;
   logic [DATA_W:0] chk_sub;

   always_comb begin
      chk_add = {1'b0, opd_a} + {1'b0, opd_b};
      chk_sub = {1'b0, opd_a} - {1'b0, opd_b};
      if (fn_sel == FN_ADD) begin
         AST_ADD_MATCHES: assert ({carry_out, result} == chk_add) else $error("add mismatch"); // R3
      end
      if (fn_sel == FN_SUB) begin
         AST_SUB_DIFF: assert (result == chk_sub[DATA_W-1:0]) else $error("sub mismatch"); // R4
         AST_SUB_NO_BORROW: assert (carry_out == (opd_a >= opd_b)) else $error("borrow mismatch"); // R4
      end
      if (fn_sel == FN_SLT) begin
         AST_SLT_BIT: assert (result == {{(DATA_W-1){1'b0}}, ($signed(opd_a) < $signed(opd_b))})
            else $error("slt mismatch"); // R6
      end
      if (fn_is_defined(fn_sel) && !fn_is_arith(fn_sel)) begin
         AST_LOGIC_QUIET: assert (!overflow && !carry_out) else $error("flags on logical op"); // R9
      end
      if (!fn_is_defined(fn_sel)) begin
         AST_BAD_CODE_QUIET: assert (result == '0 && !zero && !overflow && !carry_out)
            else $error("undefined code not blanked"); // R10
      end
      if (zero) begin
         AST_ZERO_MEANS_CLEAR: assert (result == '0 && fn_is_defined(fn_sel)) else $error("zero wrong"); // R8
      end
   end
endmodule

// File: tb/bsalu_top_bench.sv
`timescale 1ns/1ps
module bsalu_top_bench;
   localparam int W = 32;
   localparam int N_RAND = 3000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [W-1:0] a, b, res;
   logic [3:0]   fn;
   logic         z, v, c;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   bsalu_top #(.DATA_W(W)) u_bsalu_top (
      .opd_a(a), .opd_b(b), .fn_sel(fn),
      .result(res), .zero(z), .overflow(v), .carry_out(c)
   );

   task automatic model(input logic [W-1:0] ma, input logic [W-1:0] mb, input logic [3:0] mf,
                        output logic [W-1:0] er, output logic ez, output logic ev,
                        output logic ec, output string tag);
      logic [W:0] s;
      logic ok;
      er = '0; ev = 1'b0; ec = 1'b0; ok = 1'b1;
      case (mf)
         4'b0000: begin er = ma & mb; tag = "R1"; end
         4'b0001: begin er = ma | mb; tag = "R2"; end
         4'b0010: begin
            s = {1'b0, ma} + {1'b0, mb}; er = s[W-1:0]; ec = s[W];
            ev = (ma[W-1] == mb[W-1]) && (er[W-1] != ma[W-1]); tag = "R3/R5";
         end
         4'b0110: begin
            er = ma - mb; ec = (ma >= mb);
            ev = (ma[W-1] != mb[W-1]) && (er[W-1] != ma[W-1]); tag = "R4/R5";
         end
         4'b0111: begin er = {{(W-1){1'b0}}, ($signed(ma) < $signed(mb))}; tag = "R6"; end
         4'b1100: begin er = ~(ma | mb); tag = "R7"; end
         default: begin ok = 1'b0; tag = "R10"; end
      endcase
      ez = ok && (er == '0);
   endtask

   task automatic apply_and_check(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic [3:0] tf);
      logic [W-1:0] er; logic ez, ev, ec; string tag;
      @(posedge clk); #1;
      a = ta; b = tb_; fn = tf;
      model(ta, tb_, tf, er, ez, ev, ec, tag);
      @(negedge clk);
      n_checks++;
      if (res !== er) begin n_fail++;
         $display("FAIL %s result fn=%b a=%h b=%h got %h exp %h", tag, tf, ta, tb_, res, er); end
      n_checks++;
      if (z !== ez) begin n_fail++;
         $display("FAIL R8 zero fn=%b a=%h b=%h got %b exp %b", tf, ta, tb_, z, ez); end
      n_checks++;
      if (v !== ev) begin n_fail++;
         $display("FAIL %s overflow(R5/R9) fn=%b a=%h b=%h got %b exp %b", tag, tf, ta, tb_, v, ev); end
      n_checks++;
      if (c !== ec) begin n_fail++;
         $display("FAIL %s carry(R3/R4/R9) fn=%b a=%h b=%h got %b exp %b", tag, tf, ta, tb_, c, ec); end
   endtask

   initial begin
      logic [3:0] codes [6];
      logic [W-1:0] edge_v [8];
      codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
      edge_v = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                 32'h8000_0001, 32'hAAAA_5555, 32'h5555_AAAA};
      a = '0; b = '0; fn = 4'b0000;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset-state check: idle inputs give AND of zeros -> zero set (R1, R8)
      apply_and_check('0, '0, 4'b0000);
      // corner operands across every defined code (R1..R9)
      for (int f = 0; f < 6; f++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               apply_and_check(edge_v[i], edge_v[j], codes[f]);
      // R6 with overflowing difference: most negative vs positive and reverse
      apply_and_check(32'h8000_0000, 32'h0000_0001, 4'b0111);
      apply_and_check(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111);
      // R5 exact boundaries
      apply_and_check(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010);
      apply_and_check(32'h7FFF_FFFE, 32'h0000_0001, 4'b0010);
      apply_and_check(32'h8000_0000, 32'h0000_0001, 4'b0110);
      // R8 zero from subtract of equal operands, R4 carry with no borrow
      apply_and_check(32'h1234_5678, 32'h1234_5678, 4'b0110);
      // R10 every undefined code, with operands that would give nonzero
      for (int k = 0; k < 16; k++) begin
         logic [3:0] kk;
         kk = 4'(k);
         if (!(kk inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100})) begin
            apply_and_check(32'hFFFF_FFFF, 32'h0000_0001, kk);
            apply_and_check('0, '0, kk);
         end
      end
      // random operands and codes
      for (int r = 0; r < N_RAND; r++)
         apply_and_check($urandom, $urandom, 4'($urandom));
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired got hang exp completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule